// File: doc/BRIEF.md
# Tri-State Aware Watchdog Monitor

This block supervises a processor by watching a single activity line that the software is expected to toggle on a regular basis. If the line is actively driven but stays at one level for a full timeout interval, the block pulls its active-low watchdog output low. That output is normally wired to the processor's non-maskable interrupt. A flag supplied by external sensing logic reports whether the activity line is driven or left floating. While the line floats, the timer is held at zero and the watchdog function is disabled.

The timer is also held cleared while the system reset generator asserts reset, so counting starts only after reset is released and the line is driven. Independently of the timer, the output goes low whenever the supply-good flag drops. With the activity line floating, the output therefore acts as a plain low-line indicator. The activity level passes through a two-flop synchronizer before edge detection, and the timeout length is given as a count of clock cycles.

Top module: `wdog_monitor`

## Requirements
- R1: With reset released, the line driven and the supply good, `wdt_n` stays high through the first `TIMEOUT_CYCLES`-1 consecutive quiet clock edges after the counter was last cleared and goes low right after the `TIMEOUT_CYCLES`-th such edge.
- R2: While `sys_rst` is 1, the timer and the timeout state are cleared asynchronously, so `wdt_n` equals `supply_ok`.
- R3: While `wd_driven` is 0, the timer and any pending timeout are cleared at each clock edge, so `wdt_n` follows only `supply_ok` however long the line floats.
- R4: Counting begins at the first clock edge after `sys_rst` falls while `wd_driven` is 1.
- R5: `wdt_n` is 0 whenever `supply_ok` is 0, in the same cycle and without waiting for a clock edge, whatever the timer state.
- R6: Once it is low because of a timeout, `wdt_n` stays low until a valid toggle is seen, the line floats, or reset is asserted.
- R7: A change on `wd_level` clears the timer at the third rising clock edge after the change, the latency of the two-flop synchronizer plus the edge detector.
- R8: Rising and falling changes of `wd_level` clear the timer equally, and a change that arrives after the timeout returns `wdt_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sys_rst | input | 1 | Reset asserted by the reset generator, active high, asynchronous |
| wd_level | input | 1 | Level of the processor activity line, asynchronous |
| wd_driven | input | 1 | 1 when the activity line is driven, 0 when it floats |
| supply_ok | input | 1 | 1 while the supply is above the reset threshold |
| wdt_n | output | 1 | Active-low watchdog and low-line output |

## Verification
The low-line result (R5) is combinational. It is checked a fraction of a nanosecond after `supply_ok` changes, with no clock edge in between. Every other result is due one clock edge after the stimulus is sampled. The exception is a level change, which takes effect at the third edge (R7). The bench applies its inputs at the falling edge, advances a requirement-level model at the next rising edge, and compares `wdt_n` at the falling edge that follows. Directed toggles placed one cycle either side of the timeout boundary confirm the three-edge latency exactly.

// File: rtl/wdog_monitor.sv
module wdog_monitor #(
  parameter int TIMEOUT_CYCLES = 200_000_000,
  localparam int CW = $clog2(TIMEOUT_CYCLES + 1)
) (
  input  logic clk,
  input  logic sys_rst,
  input  logic wd_level,
  input  logic wd_driven,
  input  logic supply_ok,
  output logic wdt_n
);

  logic          sync_a, sync_b, sync_prev;
  logic          sync_edge;
  logic [CW-1:0] cnt;
  logic          expired;

  always_ff @(posedge clk or posedge sys_rst) begin
    if (sys_rst) begin
      sync_a    <= 1'b0;
      sync_b    <= 1'b0;
      sync_prev <= 1'b0;
    end else begin
      sync_a    <= wd_level;
      sync_b    <= sync_a;
      sync_prev <= sync_b;
    end
  end

  assign sync_edge = sync_b ^ sync_prev;

  always_ff @(posedge clk or posedge sys_rst) begin
    if (sys_rst) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else if (!wd_driven || sync_edge) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else if (!expired) begin
      if (cnt == CW'(TIMEOUT_CYCLES - 1)) expired <= 1'b1;
      else                                cnt     <= cnt + 1'b1;
    end
  end

  assign wdt_n = supply_ok & ~expired;

endmodule

// File: rtl/wdog_monitor_chk.sv
module wdog_monitor_chk #(
  parameter int TIMEOUT_CYCLES = 16,
  parameter int CW = 5
) (
  input logic          clk,
  input logic          sys_rst,
  input logic          wd_driven,
  input logic          supply_ok,
  input logic          wdt_n,
  input logic [CW-1:0] cnt,
  input logic          expired,
  input logic          sync_edge
);

  AST_RST_CLEARS: assert property (@(posedge clk) sys_rst |-> (cnt == '0 && !expired && wdt_n == supply_ok)); // R2
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (sys_rst) cnt <= CW'(TIMEOUT_CYCLES - 1)); // R1
  AST_EXPIRE_AT_LIMIT: assert property (@(posedge clk) disable iff (sys_rst) $rose(expired) |-> $past(cnt) == CW'(TIMEOUT_CYCLES - 1)); // R1
  AST_FLOAT_CLEARS: assert property (@(posedge clk) disable iff (sys_rst) !wd_driven |=> (cnt == '0 && !expired)); // R3
  AST_LOW_LINE: assert property (@(posedge clk) disable iff (sys_rst) !supply_ok |-> !wdt_n); // R5
  AST_TIMEOUT_HELD: assert property (@(posedge clk) disable iff (sys_rst) (expired && wd_driven && !sync_edge) |=> expired); // R6
  AST_EDGE_CLEARS: assert property (@(posedge clk) disable iff (sys_rst) (wd_driven && sync_edge) |=> (cnt == '0 && !expired)); // R8

endmodule

bind wdog_monitor wdog_monitor_chk #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES), .CW(CW)) i_chk (
  .clk(clk), .sys_rst(sys_rst), .wd_driven(wd_driven), .supply_ok(supply_ok),
  .wdt_n(wdt_n), .cnt(cnt), .expired(expired), .sync_edge(sync_edge)
);

// File: tb/test_wdog_monitor.sv
module test_wdog_monitor;
  localparam int T = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic sys_rst, wd_level, wd_driven, supply_ok;
  logic wdt_n;

  wdog_monitor #(.TIMEOUT_CYCLES(T)) i_wdog_monitor (
    .clk(clk), .sys_rst(sys_rst), .wd_level(wd_level),
    .wd_driven(wd_driven), .supply_ok(supply_ok), .wdt_n(wdt_n)
  );

  int checks = 0, errors = 0;
  bit m_s1, m_s2, m_s3, m_exp;
  int m_cnt;
  logic lvl;

  function automatic logic expect_out(input logic sup, input bit exp_flag);
    return sup & ~exp_flag;
  endfunction

  task automatic check(input logic got, input logic want, input string tag);
    checks++;
    if (got !== want) begin
      errors++;
      $display("FAIL %s: wdt_n got %b expected %b at %0t", tag, got, want, $time);
    end
  endtask

  task automatic step(input logic r, input logic lv, input logic dv, input logic sp, input string tag);
    bit e;
    sys_rst = r; wd_level = lv; wd_driven = dv; supply_ok = sp;
    @(posedge clk);
    if (r) begin
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_cnt = 0; m_exp = 0;
    end else begin
      e = m_s2 ^ m_s3;
      if (!dv || e) begin m_cnt = 0; m_exp = 0; end
      else if (!m_exp) begin
        if (m_cnt == T - 1) m_exp = 1;
        else m_cnt++;
      end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = lv;
    end
    @(negedge clk);
    check(wdt_n, expect_out(sp, m_exp), tag);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, got running expected done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    lvl = 0;
    sys_rst = 1; wd_level = 0; wd_driven = 1; supply_ok = 1;
    @(negedge clk);
    repeat (3) step(1, 0, 1, 1, "R2 reset state");

    // R4 / R1: quiet count from release, boundary at T
    for (int i = 0; i < T - 1; i++) step(0, 0, 1, 1, "R4 R1 before limit");
    step(0, 0, 1, 1, "R1 timeout at limit");
    check(wdt_n, 1'b0, "R1 low after limit");
    for (int i = 0; i < 5; i++) step(0, 0, 1, 1, "R6 held low");
    // R8 rising change returns output high after three edges (R7)
    step(0, 1, 1, 1, "R7 edge 1");
    step(0, 1, 1, 1, "R7 edge 2");
    check(wdt_n, 1'b0, "R7 still low before third edge");
    step(0, 1, 1, 1, "R8 rising clears");
    check(wdt_n, 1'b1, "R8 high after rising change");

    // R7 boundary: falling change timed so the clear lands just in time
    for (int i = 0; i < T - 3; i++) step(0, 1, 1, 1, "R7 quiet");
    for (int i = 0; i < 3; i++) step(0, 0, 1, 1, "R7 clear on time");
    check(wdt_n, 1'b1, "R7 falling change in time");
    // one cycle late: timeout fires first
    for (int i = 0; i < T - 2; i++) step(0, 0, 1, 1, "R7 quiet late");
    step(0, 1, 1, 1, "R7 late 1");
    step(0, 1, 1, 1, "R7 late 2");
    check(wdt_n, 1'b0, "R7 late change loses to timeout");
    step(0, 1, 1, 1, "R8 late clear");

    // R3: expire, then float
    for (int i = 0; i < T + 2; i++) step(0, 1, 1, 1, "R3 prepare");
    check(wdt_n, 1'b0, "R3 expired before float");
    step(0, 1, 0, 1, "R3 float clears");
    check(wdt_n, 1'b1, "R3 high while floating");
    for (int i = 0; i < 3 * T; i++) step(0, 1, 0, 1, "R3 long float");
    // R5 combinational low line while floating
    supply_ok = 0; #1;
    check(wdt_n, 1'b0, "R5 immediate low line");
    supply_ok = 1; #1;
    check(wdt_n, 1'b1, "R5 recovers with supply");
    @(negedge clk);

    // R2: expire, then reset clears
    for (int i = 0; i < T + 2; i++) step(0, 1, 1, 1, "R2 prepare");
    sys_rst = 1; #1;
    check(wdt_n, 1'b1, "R2 async clear");
    @(negedge clk);
    step(1, 1, 1, 1, "R2 held");
    step(1, 1, 1, 0, "R2 R5 reset with low supply");

    // random phases
    for (int ph = 0; ph < 20; ph++) begin
      int pct;
      case ($urandom_range(0, 3))
        0: pct = 0;
        1: pct = 3;
        2: pct = 12;
        default: pct = 50;
      endcase
      for (int i = 0; i < 200; i++) begin
        logic r, dv, sp;
        r  = ($urandom_range(0, 199) == 0);
        dv = ($urandom_range(0, 19) != 0);
        sp = ($urandom_range(0, 49) != 0);
        if ($urandom_range(0, 99) < pct) lvl = ~lvl;
        step(r, lvl, dv, sp, "R1 R3 R5 R6 R8 random");
      end
    end
    finish_run();
  end
endmodule